// File: doc/BRIEF.md
# Banked GPIO Controller with Half-Word Masked Output Writes

This block is a memory-mapped general-purpose I/O controller for a chip's peripheral bus. Its pins are grouped into four banks of 32, 22, 32 and 32 pins, and all pads are numbered on one flat vector with the banks laid end to end in bank order. Each pad appears as three separate bits: an input, an output value and an output enable. Each bank holds its own direction, output-enable and output-value registers. Software can also read back the bank's synchronized input levels.

The output value of any group of pins within a 16-pin half of a bank can be changed in a single bus write, with no read-modify-write. In that write, the upper half-word is an active-low mask and the lower half-word carries the new values. Each bank also has a small interrupt unit. For each pin it offers a selectable level or edge event, a polarity, an any-edge option, and enable, disable and status registers. All of it folds into one interrupt line.

The bus has separate single-cycle read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every output value and every output enable is 0, the interrupt line is low, all interrupt mask bits of existing pins are 1, all type bits are 1 (edge), and bank 0 direction reads 0x00000180.
- R2: A write to offset 0x000 + 8×bank updates output pins 0–15 of that bank from data bits 15:0. Pin i changes only when mask bit 16+i is 0; pins whose mask bit is 1 keep their value.
- R3: A write to offset 0x004 + 8×bank does the same for pins 16–31, with data bit i going to pin 16+i. Both of these mask/data offsets, like the interrupt enable and disable offsets, read as 0.
- R4: The direction register is at 0x204 + 0x40×bank (1 = output) and the output-enable register is at 0x208 + 0x40×bank. A pad's output enable is high exactly when both of its bits are 1.
- R5: In bank 0, direction bits 7 and 8 always read 1, and writing 0 to them has no effect.
- R6: Register bits for bank 1 pins 22–31 read 0 and ignore writes. Reads of any offset that is not mapped return 0.
- R7: Offset 0x060 + 4×bank returns the bank's pad inputs after a two-flop synchronizer. A read issued in the cycle after an input change returns the old value; a read issued three or more cycles later returns the new one.
- R8: The mask register reads at 0x20C + 0x40×bank. Writing 1s to 0x210 + 0x40×bank clears the matching mask bits, and writing 1s to 0x214 + 0x40×bank sets them.
- R9: With the type bit (0x21C + 0x40×bank) at 1, a status bit is set on an edge of the synchronized input. The edge is rising if the polarity bit (0x220 + 0x40×bank) is 1 and falling if it is 0. When the any-edge bit (0x224 + 0x40×bank) is 1, both edges set it.
- R10: With the type bit at 0, the status bit is set in every cycle that the synchronized input equals the polarity bit. A set in the same cycle as a clear wins.
- R11: Status at 0x218 + 0x40×bank is cleared by writing 1s. The interrupt line is the OR of all status bits whose mask bit is 0.
- R12: Read data holds the addressed value in the cycle after the read strobe, and is 0 in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 118 | Pad input levels, banks packed in order |
| pad_out | output | 118 | Pad output values |
| pad_oe | output | 118 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench first aims at the half-word masked writes. It mixes masked and unmasked bits in one write and sends a fully masked write. A design that inverted the mask sense, or that wrote across the half-word boundary, would disturb pins that should keep their values. It probes the 22-pin bank and the two forced-output pins. A design that let those bits through would read back ones above pin 21 or zeros at bits 7 and 8.

It reads the input register one cycle after a pad change and again later, which catches a synchronizer that is too short or missing. The interrupt cases separate rising, falling, any-edge and level detection, and check that a level event survives a same-cycle clear. A wrong polarity decode, a clear that beats the set, or an enable or disable with swapped sense would all show on the interrupt line.

// File: rtl/gbc_pkg.sv
package gbc_pkg;

    localparam int NUM_BANKS = 4;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = DATA_W / 2;
    localparam int ADDR_W    = 12;

    // register offsets and per-bank strides (byte addresses)
    localparam int OFS_MD_LO  = 'h000;
    localparam int OFS_MD_HI  = 'h004;
    localparam int MD_STRIDE  = 8;
    localparam int OFS_DIN    = 'h060;
    localparam int DIN_STRIDE = 4;
    localparam int OFS_DIR    = 'h204;
    localparam int OFS_OE     = 'h208;
    localparam int OFS_IMASK  = 'h20C;
    localparam int OFS_IEN    = 'h210;
    localparam int OFS_IDIS   = 'h214;
    localparam int OFS_ISTS   = 'h218;
    localparam int OFS_ITYPE  = 'h21C;
    localparam int OFS_IPOL   = 'h220;
    localparam int OFS_IANY   = 'h224;
    localparam int CFG_STRIDE = 'h40;

    function automatic int bank_pins(input int b);
        case (b)
            1:       return 22;
            default: return 32;
        endcase
    endfunction

    function automatic int bank_base(input int b);
        int sum;
        sum = 0;
        for (int k = 0; k < b; k++) sum += bank_pins(k);
        return sum;
    endfunction

    function automatic int total_pins();
        return bank_base(NUM_BANKS);
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] oe;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] ists;
        logic [DATA_W-1:0] itype;
        logic [DATA_W-1:0] ipol;
        logic [DATA_W-1:0] iany;
        logic [DATA_W-1:0] prev;
    } bank_state_t;

endpackage

// File: rtl/gbc_sync.sv
module gbc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gbc_bank.sv
module gbc_bank
    import gbc_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int PINS     = 32,
    parameter int AW       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [DATA_W-1:0] rd_val,
    output logic              irq
);
    localparam logic [DATA_W:0]   ONE_SH = (DATA_W+1)'(1) << PINS;
    localparam logic [DATA_W-1:0] VMASK  = DATA_W'(ONE_SH - (DATA_W+1)'(1));
    localparam logic [DATA_W-1:0] FORCE  = (BANK_IDX == 0) ? DATA_W'('h180) : '0;

    localparam logic [AW-1:0] A_MD_LO = AW'(OFS_MD_LO + MD_STRIDE  * BANK_IDX);
    localparam logic [AW-1:0] A_MD_HI = AW'(OFS_MD_HI + MD_STRIDE  * BANK_IDX);
    localparam logic [AW-1:0] A_DIN   = AW'(OFS_DIN   + DIN_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_DIR   = AW'(OFS_DIR   + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_OE    = AW'(OFS_OE    + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_IMASK = AW'(OFS_IMASK + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_IEN   = AW'(OFS_IEN   + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_IDIS  = AW'(OFS_IDIS  + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_ISTS  = AW'(OFS_ISTS  + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_ITYPE = AW'(OFS_ITYPE + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_IPOL  = AW'(OFS_IPOL  + CFG_STRIDE * BANK_IDX);
    localparam logic [AW-1:0] A_IANY  = AW'(OFS_IANY  + CFG_STRIDE * BANK_IDX);

    localparam bank_state_t RST_VAL = '{
        dout:  '0,
        dir:   FORCE,
        oe:    '0,
        imask: VMASK,
        ists:  '0,
        itype: VMASK,
        ipol:  '0,
        iany:  '0,
        prev:  '0
    };

    bank_state_t       st_d, st_q;
    logic [PINS-1:0]   sync_in;
    logic [DATA_W-1:0] din_w;
    logic [DATA_W-1:0] rise, fall, edge_hit, lvl_hit, evt;

    gbc_sync #(.WIDTH(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (sync_in)
    );

    always_comb begin
        din_w             = '0;
        din_w[PINS-1:0]   = sync_in;
    end

    // event detection on synchronized inputs
    always_comb begin
        rise     = din_w & ~st_q.prev;
        fall     = ~din_w & st_q.prev;
        edge_hit = (st_q.iany & (rise | fall))
                 | (~st_q.iany & st_q.ipol & rise)
                 | (~st_q.iany & ~st_q.ipol & fall);
        lvl_hit  = (st_q.ipol & din_w) | (~st_q.ipol & ~din_w);
        evt      = ((st_q.itype & edge_hit) | (~st_q.itype & lvl_hit)) & VMASK;
    end

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.prev = din_w;
        if (wr_en) begin
            case (addr)
                A_MD_LO: begin
                    for (int i = 0; i < HALF_W; i++)
                        if (!wdata[HALF_W+i]) st_d.dout[i] = wdata[i];
                end
                A_MD_HI: begin
                    for (int i = 0; i < HALF_W; i++)
                        if (!wdata[HALF_W+i]) st_d.dout[HALF_W+i] = wdata[i];
                end
                A_DIR:   st_d.dir   = wdata;
                A_OE:    st_d.oe    = wdata;
                A_IEN:   st_d.imask = st_q.imask & ~wdata;
                A_IDIS:  st_d.imask = st_q.imask | wdata;
                A_ISTS:  st_d.ists  = st_q.ists & ~wdata;
                A_ITYPE: st_d.itype = wdata;
                A_IPOL:  st_d.ipol  = wdata;
                A_IANY:  st_d.iany  = wdata;
                default: ;
            endcase
        end
        // new events win over a same-cycle clear
        st_d.ists  = st_d.ists | evt;
        // unimplemented pins stay zero, forced outputs stay one
        st_d.dout  = st_d.dout  & VMASK;
        st_d.dir   = (st_d.dir  & VMASK) | FORCE;
        st_d.oe    = st_d.oe    & VMASK;
        st_d.imask = st_d.imask & VMASK;
        st_d.ists  = st_d.ists  & VMASK;
        st_d.itype = st_d.itype & VMASK;
        st_d.ipol  = st_d.ipol  & VMASK;
        st_d.iany  = st_d.iany  & VMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    // read view
    always_comb begin
        case (addr)
            A_DIN:   rd_val = din_w;
            A_DIR:   rd_val = st_q.dir;
            A_OE:    rd_val = st_q.oe;
            A_IMASK: rd_val = st_q.imask;
            A_ISTS:  rd_val = st_q.ists;
            A_ITYPE: rd_val = st_q.itype;
            A_IPOL:  rd_val = st_q.ipol;
            A_IANY:  rd_val = st_q.iany;
            default: rd_val = '0;
        endcase
    end

    assign pad_out = st_q.dout[PINS-1:0];
    assign pad_oe  = st_q.dir[PINS-1:0] & st_q.oe[PINS-1:0];
    assign irq     = |(st_q.ists & ~st_q.imask);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gbc_pkg::*;
#(
    parameter int AW = gbc_pkg::ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [AW-1:0]           addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [total_pins()-1:0] pad_in,
    output logic [total_pins()-1:0] pad_out,
    output logic [total_pins()-1:0] pad_oe,
    output logic                    irq
);
    localparam int NPINS = total_pins();

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic [DATA_W-1:0] rd_or;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int PB  = bank_pins(b);
        localparam int OFF = bank_base(b);
        gbc_bank #(
            .BANK_IDX(b),
            .PINS    (PB),
            .AW      (AW)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .addr   (addr),
            .wdata  (wdata),
            .pad_in (pad_in[OFF +: PB]),
            .pad_out(pad_out[OFF +: PB]),
            .pad_oe (pad_oe[OFF +: PB]),
            .rd_val (bank_rd[b]),
            .irq    (bank_irq[b])
        );
    end

    always_comb begin
        rd_or = '0;
        for (int b = 0; b < NUM_BANKS; b++) rd_or = rd_or | bank_rd[b];
        st_d       = st_q;
        st_d.rdata = rd_en ? rd_or : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = |bank_irq;
endmodule

// File: rtl/gbc_checker.sv
module gbc_checker #(
    parameter int AW    = 12,
    parameter int NPINS = 118
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [31:0]      rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);
    logic was_rst;

    always_ff @(posedge clk) begin
        if (rst_n && was_rst === 1'b1) begin
            p_reset_clear_r1: assert (pad_out == '0 && pad_oe == '0)
                else $error("R1: outputs not cleared by reset");
        end
        was_rst <= !rst_n;
    end

    p_out_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_out));

    p_wo_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < AW'('h060)) |=> rdata == '0);

    p_oe_only_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pad_oe));

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'('h100)) |=> rdata == '0);

    p_idle_rdata_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

bind gpio_bank_ctrl gbc_checker #(.AW(AW), .NPINS(gbc_pkg::total_pins())) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
    localparam int NP = gbc_pkg::total_pins();
    localparam int B2 = gbc_pkg::bank_base(2);
    localparam int B3 = gbc_pkg::bank_base(3);

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0, rd_en = 0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic rd_seen = 0;
    rd_item_t exp_q[$];

    always #4 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare each registered read result against the scoreboard
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R12: unexpected read result %h expected none", rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk(rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        chk(pad_out[31:0], 32'h0, "R1 pad_out");
        chk(pad_oe[31:0], 32'h0, "R1 pad_oe");
        chk({31'h0, irq}, 32'h0, "R1 irq");
        chk(rdata, 32'h0, "R12 idle rdata");
        rd(12'h204, 32'h0000_0180, "R1 R5 bank0 dir reset");
        rd(12'h20C, 32'hFFFF_FFFF, "R1 bank0 mask reset");
        rd(12'h21C, 32'hFFFF_FFFF, "R1 bank0 type reset");
        rd(12'h24C, 32'h003F_FFFF, "R6 bank1 mask reset");

        // R2 lower half masked writes
        wr(12'h000, 32'h0000_A5A5);
        chk(pad_out[31:0], 32'h0000_A5A5, "R2 unmasked lower write");
        wr(12'h000, 32'hFF00_00FF);
        chk(pad_out[31:0], 32'h0000_A5FF, "R2 partial mask");
        // R3 upper half of bank 2
        wr(12'h014, 32'h0000_1234);
        chk({16'h0, pad_out[B2+16 +: 16]}, 32'h0000_1234, "R3 bank2 upper");
        chk({16'h0, pad_out[B2 +: 16]}, 32'h0, "R3 bank2 lower untouched");
        wr(12'h014, 32'hFFFF_5555);
        chk({16'h0, pad_out[B2+16 +: 16]}, 32'h0000_1234, "R2 fully masked write");
        rd(12'h000, 32'h0, "R3 mask/data reads zero");
        // R6 bank1 upper half, only 6 pins exist
        wr(12'h00C, 32'h0000_FFFF);
        chk({26'h0, pad_out[53:48]}, 32'h3F, "R6 bank1 top pins");
        chk(pad_out[B2+16 +: 16], 16'h1234, "R6 no spill into bank2");
        wr(12'h244, 32'hFFFF_FFFF);
        rd(12'h244, 32'h003F_FFFF, "R6 bank1 dir width");
        rd(12'h100, 32'h0, "R6 unmapped offset");

        // R4 R5 direction and enable
        wr(12'h204, 32'h0000_000F);
        rd(12'h204, 32'h0000_018F, "R5 forced dir bits");
        wr(12'h208, 32'hFFFF_FFFF);
        chk(pad_oe[31:0], 32'h0000_018F, "R4 oe is dir and enable");
        wr(12'h204, 32'h0);
        rd(12'h204, 32'h0000_0180, "R5 zero write ignored");
        chk(pad_oe[31:0], 32'h0000_0180, "R4 R5 forced outputs drive");

        // R7 synchronized input read
        @(negedge clk);
        pad_in[B3 +: 32] = 32'hDEAD_BEEF;
        rd(12'h06C, 32'h0, "R7 sync latency");
        wait_cyc(2);
        rd(12'h06C, 32'hDEAD_BEEF, "R7 bank3 input");

        // R8 R9 R11 interrupts on bank 3 pin 0
        wr(12'h2D8, 32'hFFFF_FFFF);
        wr(12'h2E0, 32'h0000_0001);
        wr(12'h2D0, 32'h0000_0001);
        rd(12'h2CC, 32'hFFFF_FFFE, "R8 enable clears mask");
        rd(12'h2D0, 32'h0, "R3 enable reads zero");
        @(negedge clk); pad_in[B3] = 1'b0;
        wait_cyc(4);
        chk({31'h0, irq}, 32'h0, "R9 falling ignored on rising");
        @(negedge clk); pad_in[B3] = 1'b1;
        wait_cyc(4);
        chk({31'h0, irq}, 32'h1, "R9 rising edge");
        rd(12'h2D8, 32'h0000_0001, "R11 status bit");
        wr(12'h2D8, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R11 write one clears");
        wr(12'h2E4, 32'h0000_0001);
        @(negedge clk); pad_in[B3] = 1'b0;
        wait_cyc(4);
        chk({31'h0, irq}, 32'h1, "R9 any edge falling");
        wr(12'h2D8, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R11 clear after any edge");

        // R10 level detection
        wr(12'h2DC, 32'hFFFF_FFFE);
        @(negedge clk); pad_in[B3] = 1'b1;
        wait_cyc(4);
        chk({31'h0, irq}, 32'h1, "R10 level high");
        wr(12'h2D8, 32'h0000_0001);
        rd(12'h2D8, 32'h0000_0001, "R10 set beats clear");
        @(negedge clk); pad_in[B3] = 1'b0;
        wait_cyc(4);
        wr(12'h2D8, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R10 level gone");

        // R8 disable masks active level
        @(negedge clk); pad_in[B3] = 1'b1;
        wait_cyc(4);
        chk({31'h0, irq}, 32'h1, "R10 level again");
        wr(12'h2D4, 32'h0000_0001);
        chk({31'h0, irq}, 32'h0, "R8 disable masks");
        rd(12'h2CC, 32'hFFFF_FFFF, "R8 mask set");

        wait_cyc(3);
        chk(exp_q.size(), 0, "R12 all reads returned");
        finish_run();
    end
endmodule